// File: doc/BRIEF.md
# Framed Response Receiver with Automatic Wait Extension

This block collects a response packet from a device through a byte-wide read FIFO. It reads a byte only when the device reports that read data is available. It reads a four-byte header and decides from it what to do next. A data packet is streamed out as a payload byte stream, with a flag on the final byte. The first six bytes of its body are an inner header and are dropped. An error packet is told apart by its fifth byte, which may mark a negative acknowledgement. An abort acknowledgement ends the receive.

When the device asks for more processing time, the block answers by itself. It pushes a four-byte packet into the device's write FIFO, and writes only while the device reports that its transmit FIFO is empty. Each request is granted until a bounded number of grants has been given in the current receive. The next request is then refused with an abort packet. After each answer the block waits for a fixed number of idle cycles and then starts reading a new header.

Every wait on a status bit is polled at a fixed spacing. The wait gives up after a bounded number of failed polls. Each receive ends with a one-cycle done pulse and a result code that stays valid until the next receive ends.

Top module: `ext_frame_rx`

## Requirements
- R1: While reset is high and after it, `rd_pop`, `wr_push`, `pay_valid`, `pay_last` and `rx_done` are low and `rx_status` is 0. A receive starts only when `start` is seen high while the block is idle.
- R2: A byte is popped from the read FIFO (`rd_pop` high for one cycle) only after a poll saw `dev_stat` bit 7 high. While that bit stays low, nothing is popped.
- R3: A byte is pushed to the write FIFO (`wr_push` high for one cycle) only after a poll saw `dev_stat` bit 0 high. While that bit stays low, nothing is pushed.
- R4: A header is version, control, length high and length low, in that order. If the version is 0x01 and the control is 0x04, the block reads the number of body bytes given by the length. It drops body bytes 0 to 5 and delivers the remaining bytes in order on `pay_byte` with `pay_valid`. `pay_last` marks the final byte, and the receive ends with status 0 (ok). A length of 6 or less delivers no bytes and still ends with status 0.
- R5: A version byte other than 0x01, or a control byte other than 0x04, 0x10, 0x18 or 0x20, ends the receive after the fourth header byte with status 1 (protocol error).
- R6: Control 0x10 with fewer than MAX_GRANTS grants given in this receive: the block writes 0x01, 0x10, 0x00, 0x00, counts the grant, and then reads a new header.
- R7: Control 0x10 with MAX_GRANTS grants already given: the block writes 0x01, 0x18, 0x00, 0x00, clears the grant count, and then reads a new header.
- R8: Control 0x18 ends the receive with status 4 (abort acknowledged).
- R9: Control 0x20 makes the block read one more byte. If that byte is 0x15, the receive ends with status 2 (negative acknowledgement); any other value ends it with status 1.
- R10: A wait on a status bit polls every POLL_GAP cycles. After MAX_POLLS failed polls the receive ends with status 3 (timeout). With the bit never set, `rx_done` rises 1 + (MAX_POLLS-1)*POLL_GAP cycles after the cycle in which `start` was taken.
- R11: The grant count is zero at the start of every receive.
- R12: After the fourth byte of a grant or abort packet, the block leaves both FIFOs untouched for IDLE_CYCLES cycles. If data is waiting, the next pop then comes IDLE_CYCLES+2 cycles after that last push.
- R13: `start` pulses that arrive while a receive is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a receive (taken only when idle) |
| dev_stat | input | 8 | Device status byte; bit 7 read data available, bit 0 transmit FIFO empty |
| rd_pop | output | 1 | Pops the read FIFO; `rd_byte` is taken in this cycle |
| rd_byte | input | 8 | Head byte of the read FIFO |
| wr_push | output | 1 | Pushes `wr_byte` into the write FIFO |
| wr_byte | output | 8 | Byte written to the device |
| pay_valid | output | 1 | Payload byte valid |
| pay_byte | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte of the packet |
| rx_status | output | 3 | Result: 0 ok, 1 protocol error, 2 NAK, 3 timeout, 4 abort acknowledged |
| rx_done | output | 1 | One-cycle pulse at the end of a receive |

## Verification
The bench builds the block with MAX_GRANTS=2, MAX_POLLS=6, POLL_GAP=3 and IDLE_CYCLES=5. With these values the refusal after the grant limit is reached after only two requests. The timeout arrives in 17 cycles, so its exact cycle can be checked. The idle pause after each answer is short enough to measure exactly. Holding a status bit low for about ten cycles stays inside the poll window, so the bench can show that nothing moves while the bit is low, and the receive still completes once the bit is set.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam logic [7:0] VER_BYTE  = 8'h01;
  localparam logic [7:0] CTL_DATA  = 8'h04;
  localparam logic [7:0] CTL_EXT   = 8'h10;
  localparam logic [7:0] CTL_ABORT = 8'h18;
  localparam logic [7:0] CTL_ERR   = 8'h20;
  localparam logic [7:0] NAK_BYTE  = 8'h15;
  localparam int         INNER_HDR = 6;

  localparam logic [2:0] RX_OK    = 3'd0;
  localparam logic [2:0] RX_PROTO = 3'd1;
  localparam logic [2:0] RX_NAK   = 3'd2;
  localparam logic [2:0] RX_TMO   = 3'd3;
  localparam logic [2:0] RX_ABORT = 3'd4;

  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_XFER, ST_EVAL, ST_PAUSE} rx_state_e;
  typedef enum logic [1:0] {PH_HDR, PH_BODY, PH_ERRB, PH_SEND} rx_phase_e;
endpackage

// File: rtl/rx_poller.sv
module rx_poller #(
  parameter int MAX_POLLS = 5000,
  parameter int POLL_GAP  = 300000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic [2:0] bit_sel,
  input  logic [7:0] stat,
  output logic       hit,
  output logic       expired
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int GW = $clog2(POLL_GAP + 1);

  logic [GW-1:0] gap;
  logic [PW-1:0] polls;
  logic          sample;

  assign sample  = active && (gap == '0);
  assign hit     = sample && stat[bit_sel];
  assign expired = sample && !stat[bit_sel] && (polls == PW'(MAX_POLLS - 1));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      gap   <= '0;
      polls <= '0;
    end else if (sample && !hit) begin
      gap   <= GW'(POLL_GAP - 1);
      polls <= polls + 1'b1;
    end else if (gap != '0) begin
      gap <= gap - 1'b1;
    end
  end
endmodule

// File: rtl/rx_pause.sv
module rx_pause #(
  parameter int CYCLES = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= CW'(CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/ext_frame_rx.sv
module ext_frame_rx
  import rx_pkg::*;
#(
  parameter int MAX_GRANTS  = 50,
  parameter int MAX_POLLS   = 5000,
  parameter int POLL_GAP    = 300000,
  parameter int IDLE_CYCLES = 2000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] dev_stat,
  output logic       rd_pop,
  input  logic [7:0] rd_byte,
  output logic       wr_push,
  output logic [7:0] wr_byte,
  output logic       pay_valid,
  output logic [7:0] pay_byte,
  output logic       pay_last,
  output logic [2:0] rx_status,
  output logic       rx_done
);
  localparam int GCW = $clog2(MAX_GRANTS + 1);

  rx_state_e     state;
  rx_phase_e     phase;
  logic [1:0]    idx;
  logic [7:0]    hdr_ver, hdr_ctl, hdr_lenh, ans_code;
  logic [15:0]   len, bcnt;
  logic [GCW-1:0] grants;
  logic [7:0]    send_byte;
  logic          poll_hit, poll_tmo, pause_load, pause_done;

  always_comb begin
    case (idx)
      2'd0:    send_byte = VER_BYTE;
      2'd1:    send_byte = ans_code;
      default: send_byte = 8'h00;
    endcase
  end

  assign pause_load = (state == ST_XFER) && (phase == PH_SEND) && (idx == 2'd3);

  rx_poller #(.MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)) u_poll (
    .clk(clk), .rst(rst),
    .active(state == ST_WAIT),
    .bit_sel((phase == PH_SEND) ? 3'd0 : 3'd7),
    .stat(dev_stat),
    .hit(poll_hit), .expired(poll_tmo)
  );

  rx_pause #(.CYCLES(IDLE_CYCLES)) u_pause (
    .clk(clk), .rst(rst), .load(pause_load), .expired(pause_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= PH_HDR;
      idx       <= '0;
      hdr_ver   <= '0;
      hdr_ctl   <= '0;
      hdr_lenh  <= '0;
      ans_code  <= '0;
      len       <= '0;
      bcnt      <= '0;
      grants    <= '0;
      rd_pop    <= 1'b0;
      wr_push   <= 1'b0;
      wr_byte   <= '0;
      pay_valid <= 1'b0;
      pay_byte  <= '0;
      pay_last  <= 1'b0;
      rx_status <= RX_OK;
      rx_done   <= 1'b0;
    end else begin
      rd_pop    <= 1'b0;
      wr_push   <= 1'b0;
      pay_valid <= 1'b0;
      pay_last  <= 1'b0;
      rx_done   <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          grants <= '0;
          phase  <= PH_HDR;
          idx    <= '0;
          state  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (poll_hit) begin
            if (phase == PH_SEND) begin
              wr_push <= 1'b1;
              wr_byte <= send_byte;
            end else begin
              rd_pop <= 1'b1;
            end
            state <= ST_XFER;
          end else if (poll_tmo) begin
            rx_status <= RX_TMO;
            rx_done   <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_XFER: begin
          case (phase)
            PH_HDR: begin
              case (idx)
                2'd0:    hdr_ver  <= rd_byte;
                2'd1:    hdr_ctl  <= rd_byte;
                2'd2:    hdr_lenh <= rd_byte;
                default: len      <= {hdr_lenh, rd_byte};
              endcase
              if (idx == 2'd3) state <= ST_EVAL;
              else begin
                idx   <= idx + 1'b1;
                state <= ST_WAIT;
              end
            end
            PH_BODY: begin
              if (bcnt >= 16'(INNER_HDR)) begin
                pay_valid <= 1'b1;
                pay_byte  <= rd_byte;
                pay_last  <= (bcnt == len - 16'd1);
              end
              if (bcnt == len - 16'd1) begin
                rx_status <= RX_OK;
                rx_done   <= 1'b1;
                state     <= ST_IDLE;
              end else begin
                bcnt  <= bcnt + 16'd1;
                state <= ST_WAIT;
              end
            end
            PH_ERRB: begin
              rx_status <= (rd_byte == NAK_BYTE) ? RX_NAK : RX_PROTO;
              rx_done   <= 1'b1;
              state     <= ST_IDLE;
            end
            default: begin
              if (idx == 2'd3) state <= ST_PAUSE;
              else begin
                idx   <= idx + 1'b1;
                state <= ST_WAIT;
              end
            end
          endcase
        end
        ST_EVAL: begin
          if (hdr_ver != VER_BYTE) begin
            rx_status <= RX_PROTO;
            rx_done   <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            case (hdr_ctl)
              CTL_DATA: begin
                if (len == 16'd0) begin
                  rx_status <= RX_OK;
                  rx_done   <= 1'b1;
                  state     <= ST_IDLE;
                end else begin
                  bcnt  <= '0;
                  phase <= PH_BODY;
                  state <= ST_WAIT;
                end
              end
              CTL_EXT: begin
                if (grants < GCW'(MAX_GRANTS)) begin
                  grants   <= grants + 1'b1;
                  ans_code <= CTL_EXT;
                end else begin
                  grants   <= '0;
                  ans_code <= CTL_ABORT;
                end
                idx   <= '0;
                phase <= PH_SEND;
                state <= ST_WAIT;
              end
              CTL_ABORT: begin
                rx_status <= RX_ABORT;
                rx_done   <= 1'b1;
                state     <= ST_IDLE;
              end
              CTL_ERR: begin
                phase <= PH_ERRB;
                state <= ST_WAIT;
              end
              default: begin
                rx_status <= RX_PROTO;
                rx_done   <= 1'b1;
                state     <= ST_IDLE;
              end
            endcase
          end
        end
        ST_PAUSE: if (pause_done) begin
          phase <= PH_HDR;
          idx   <= '0;
          state <= ST_WAIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_frame_rx_chk.sv
module ext_frame_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] dev_stat,
  input logic       rd_pop,
  input logic       wr_push,
  input logic       pay_valid,
  input logic       pay_last,
  input logic [2:0] rx_status,
  input logic       rx_done
);
  a_r2_pop_needs_rda: assert property (@(posedge clk) disable iff (rst)
    rd_pop |-> $past(dev_stat[7]));
  a_r2_pop_single: assert property (@(posedge clk) disable iff (rst)
    rd_pop |=> !rd_pop);
  a_r3_push_needs_empty: assert property (@(posedge clk) disable iff (rst)
    wr_push |-> $past(dev_stat[0]));
  a_r3_no_mixed_access: assert property (@(posedge clk) disable iff (rst)
    !(rd_pop && wr_push));
  a_r4_last_ends_packet: assert property (@(posedge clk) disable iff (rst)
    pay_last |-> (pay_valid && rx_done && rx_status == 3'd0));
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);
  a_r4_status_range: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> (rx_status <= 3'd4));
endmodule

bind ext_frame_rx ext_frame_rx_chk u_chk (
  .clk(clk), .rst(rst), .dev_stat(dev_stat), .rd_pop(rd_pop), .wr_push(wr_push),
  .pay_valid(pay_valid), .pay_last(pay_last), .rx_status(rx_status), .rx_done(rx_done)
);

// File: tb/ext_frame_rx_test.sv
module ext_frame_rx_test;
  localparam int MG = 2, MP = 6, PG = 3, IC = 5;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic rda_on = 1'b1, txe_on = 1'b1;
  logic rd_pop, wr_push, pay_valid, pay_last, rx_done;
  logic [7:0] rd_byte, wr_byte, pay_byte, dev_stat;
  logic [2:0] rx_status;

  logic [7:0] q [0:63];
  logic [5:0] head = '0, tail = '0;
  logic [7:0] wr_log [0:255];
  logic [7:0] pay_log [0:255];
  int cyc = 0, rd_cnt = 0, wr_cnt = 0, pcnt = 0, last_cnt = 0, done_cnt = 0;
  int done_cyc = 0, last_wr = 0, gap_meas = 0;
  logic gap_pend = 1'b0;
  logic [2:0] done_st = '0;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  assign rd_byte  = q[head];
  assign dev_stat = {rda_on && (head != tail), 6'b0, txe_on};

  ext_frame_rx #(.MAX_GRANTS(MG), .MAX_POLLS(MP), .POLL_GAP(PG), .IDLE_CYCLES(IC)) uut (
    .clk(clk), .rst(rst), .start(start), .dev_stat(dev_stat), .rd_pop(rd_pop),
    .rd_byte(rd_byte), .wr_push(wr_push), .wr_byte(wr_byte), .pay_valid(pay_valid),
    .pay_byte(pay_byte), .pay_last(pay_last), .rx_status(rx_status), .rx_done(rx_done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_pop) begin
      head   <= head + 1'b1;
      rd_cnt <= rd_cnt + 1;
      if (gap_pend) begin
        gap_meas <= cyc - last_wr;
        gap_pend <= 1'b0;
      end
    end
    if (wr_push) begin
      wr_log[wr_cnt % 256] <= wr_byte;
      wr_cnt   <= wr_cnt + 1;
      last_wr  <= cyc;
      gap_pend <= 1'b1;
    end
    if (pay_valid) begin
      pay_log[pcnt % 256] <= pay_byte;
      pcnt <= pcnt + 1;
    end
    if (pay_last) last_cnt <= last_cnt + 1;
    if (rx_done) begin
      done_cnt <= done_cnt + 1;
      done_st  <= rx_status;
      done_cyc <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    q[tail] = b;
    tail = tail + 1'b1;
  endtask

  task automatic push_hdr(input logic [7:0] v, input logic [7:0] c, input logic [15:0] l);
    push(v); push(c); push(l[15:8]); push(l[7:0]);
  endtask

  task automatic kick(output int st_cyc);
    @(negedge clk);
    start = 1'b1;
    st_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int base);
    int n = 0;
    while (done_cnt == base && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done_cnt == base + 1, "R1 done reached", done_cnt - base, 1);
  endtask

  // {ver, ctl, len, extra, expected status}
  localparam logic [47:0] VEC [0:6] = '{
    {8'h01, 8'h04, 16'd9,  8'h00, 8'd0},
    {8'h01, 8'h04, 16'd6,  8'h00, 8'd0},
    {8'h02, 8'h04, 16'd9,  8'h00, 8'd1},
    {8'h01, 8'h20, 16'd1,  8'h15, 8'd2},
    {8'h01, 8'h20, 16'd1,  8'h33, 8'd1},
    {8'h01, 8'h18, 16'd0,  8'h00, 8'd4},
    {8'h01, 8'h77, 16'd0,  8'h00, 8'd1}
  };

  initial begin
    repeat (MP * PG * 0 + 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int sc, d0, p0, l0, w0, r0, npay;
    logic [7:0] ev;
    repeat (3) @(negedge clk);
    chk(!rd_pop && !wr_push && !pay_valid && !rx_done && rx_status == 3'd0,
        "R1 reset outputs", {rd_pop, wr_push, pay_valid, rx_done}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_cnt == 0 && wr_cnt == 0 && done_cnt == 0, "R1 idle without start", rd_cnt + wr_cnt, 0);

    // table of packets: R4 R5 R8 R9
    for (int i = 0; i < 7; i++) begin
      logic [7:0] v, c, x;
      logic [15:0] l;
      v = VEC[i][47:40]; c = VEC[i][39:32]; l = VEC[i][31:16]; x = VEC[i][15:8];
      d0 = done_cnt; p0 = pcnt; l0 = last_cnt;
      push_hdr(v, c, l);
      if (v == 8'h01 && c == 8'h04) for (int k = 0; k < int'(l); k++) push(8'hA0 + 8'(k));
      if (v == 8'h01 && c == 8'h20) push(x);
      kick(sc);
      wait_done(d0);
      @(negedge clk);
      chk(done_st == VEC[i][2:0], "R4/R5/R8/R9 status (vector)", done_st, VEC[i][2:0]);
      npay = (v == 8'h01 && c == 8'h04 && l > 6) ? int'(l) - 6 : 0;
      chk(pcnt - p0 == npay, "R4 payload count", pcnt - p0, npay);
      for (int j = 0; j < npay; j++)
        chk(pay_log[(p0 + j) % 256] == 8'hA6 + 8'(j), "R4 payload byte",
            pay_log[(p0 + j) % 256], 8'hA6 + j);
      chk(last_cnt - l0 == ((npay > 0) ? 1 : 0), "R4 last flag", last_cnt - l0, (npay > 0) ? 1 : 0);
      chk(head == tail, "R5 all bytes consumed", head, tail);
    end

    // R6 R7 R12: two grants, then refusal, then data
    d0 = done_cnt; p0 = pcnt; w0 = wr_cnt;
    for (int k = 0; k < 3; k++) push_hdr(8'h01, 8'h10, 16'd0);
    push_hdr(8'h01, 8'h04, 16'd7);
    for (int k = 0; k < 7; k++) push(8'hA0 + 8'(k));
    kick(sc);
    wait_done(d0);
    @(negedge clk);
    chk(done_st == 3'd0, "R6 status after grants", done_st, 0);
    chk(wr_cnt - w0 == 12, "R7 answer byte count", wr_cnt - w0, 12);
    for (int j = 0; j < 12; j++) begin
      ev = (j % 4 == 0) ? 8'h01 : (j % 4 == 1) ? ((j == 9) ? 8'h18 : 8'h10) : 8'h00;
      chk(wr_log[(w0 + j) % 256] == ev, (j == 9) ? "R7 refusal byte" : "R6 grant byte",
          wr_log[(w0 + j) % 256], ev);
    end
    chk(pcnt - p0 == 1 && pay_log[p0 % 256] == 8'hA6, "R6 data after grants", pay_log[p0 % 256], 8'hA6);
    chk(gap_meas == IC + 2, "R12 idle gap", gap_meas, IC + 2);

    // R11: end a receive with one grant outstanding, then two grants must follow
    d0 = done_cnt; w0 = wr_cnt;
    push_hdr(8'h01, 8'h10, 16'd0);
    push_hdr(8'h01, 8'h18, 16'd0);
    kick(sc);
    wait_done(d0);
    @(negedge clk);
    chk(done_st == 3'd4, "R8 abort ack status", done_st, 4);
    d0 = done_cnt; w0 = wr_cnt;
    push_hdr(8'h01, 8'h10, 16'd0);
    push_hdr(8'h01, 8'h10, 16'd0);
    push_hdr(8'h01, 8'h04, 16'd6);
    for (int k = 0; k < 6; k++) push(8'h55);
    kick(sc);
    wait_done(d0);
    @(negedge clk);
    chk(wr_cnt - w0 == 8, "R11 answer count", wr_cnt - w0, 8);
    chk(wr_log[(w0 + 5) % 256] == 8'h10, "R11 grant count cleared", wr_log[(w0 + 5) % 256], 8'h10);
    chk(done_st == 3'd0, "R11 status", done_st, 0);

    // R3: transmit-empty held low
    d0 = done_cnt; w0 = wr_cnt;
    txe_on = 1'b0;
    push_hdr(8'h01, 8'h10, 16'd0);
    push_hdr(8'h01, 8'h18, 16'd0);
    kick(sc);
    repeat (12) @(negedge clk);
    chk(wr_cnt == w0, "R3 no push while bit 0 low", wr_cnt - w0, 0);
    txe_on = 1'b1;
    wait_done(d0);
    @(negedge clk);
    chk(wr_cnt - w0 == 4 && done_st == 3'd4, "R3 push after bit 0 set", wr_cnt - w0, 4);

    // R2: read-available held low
    d0 = done_cnt; r0 = rd_cnt;
    rda_on = 1'b0;
    push_hdr(8'h01, 8'h04, 16'd7);
    for (int k = 0; k < 7; k++) push(8'h11);
    kick(sc);
    repeat (10) @(negedge clk);
    chk(rd_cnt == r0, "R2 no pop while bit 7 low", rd_cnt - r0, 0);
    rda_on = 1'b1;
    wait_done(d0);
    @(negedge clk);
    chk(rd_cnt - r0 == 11 && done_st == 3'd0, "R2 pops after bit 7 set", rd_cnt - r0, 11);

    // R10 R13: timeout with a second start mid-run
    d0 = done_cnt;
    kick(sc);
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(d0);
    @(negedge clk);
    chk(done_st == 3'd3, "R10 timeout status", done_st, 3);
    chk(done_cyc - sc == 1 + (MP - 1) * PG + 1, "R10 timeout cycle", done_cyc - sc, 1 + (MP - 1) * PG + 1);
    repeat (30) @(negedge clk);
    chk(done_cnt == d0 + 1, "R13 start while busy ignored", done_cnt - d0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule